// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three 16-bit down-counters behind a small byte-wide register bus. One channel serves as a sanity watchdog, one as the periodic system clock and one as a bus-timeout timer. Software programs a channel by first writing a control byte, which names the channel and picks how the divider is accessed a byte at a time. It then writes the divider. Every assertion of the shared `tick` input moves each running channel one step down. A channel that reaches its terminal count reloads its divider and sends a one-cycle pulse.

The clock channel (channel 1) also latches a clock-interrupt flag at every terminal count, unless the `inhibit` input from the control/status logic is high. Software acknowledges the interrupt by reading the latch-clear address. The `force_reload` input presets every running channel to one step short of a full period. The surrounding logic uses it when the timer inhibit is released.

Top module: `tri_interval_timer`

## Requirements
- R1: Bits 7:6 of a control byte written to address 3 select the channel (0, 1 or 2). The value 3 is ignored and changes no state.
- R2: A valid control write stores the whole byte as that channel's mode, disables the channel and resets its byte toggle. A read of address 3 returns the mode byte of the channel named by the last valid control write. All state is 0 after reset.
- R3: Mode bits 5:4 select divider access: 00 none, 01 low byte only, 10 high byte only, 11 alternating. In the 01 and 10 modes, a divider write (address 0, 1 or 2 for channel 0, 1 or 2) replaces one byte and keeps the other. It loads the count with the new divider and enables the channel at once.
- R4: In alternating mode the first divider write sets the low byte and the second sets the high byte, and both load the count. The channel becomes enabled only on the high-byte write.
- R5: A divider read returns the current count in the channel's access mode: low byte, high byte, or low then high in alternating mode using the same toggle as writes. In mode 00 the read returns 0.
- R6: Read data appears on `bus_rdata` in the cycle after the read strobe. Addresses 5 to 7 read 0 and ignore writes.
- R7: A read of address 4 returns 0 and clears the clock interrupt. A write there has no effect. If a channel-1 terminal count falls in the same cycle as that read, the interrupt stays set.
- R8: The clock interrupt is set at each channel-1 terminal count, but only while `inhibit` is low. Channel 1 ignores its gate input and always counts when enabled.
- R9: Each enabled, gated channel steps down by one per `tick`. A step taken from count 1 reloads the divider and pulses that channel's `tc_out` bit for one cycle, one cycle later. A divider of 0 gives a period of 65536 ticks.
- R10: A channel that is disabled, or whose gate is low (channels 0 and 2), holds its count.
- R11: `force_reload` sets every enabled, gated channel's count to its divider minus 1 and takes precedence over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled count enable, one step per cycle high |
| inhibit | input | 1 | Blocks the clock interrupt while high |
| force_reload | input | 1 | Presets running channels to divider minus 1 |
| gate | input | 3 | Per-channel gate; bit 1 is ignored |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid the cycle after a read |
| clk_irq | output | 1 | Pending clock interrupt |
| tc_out | output | 3 | Per-channel terminal-count pulse |

## Verification
The acknowledge read at address 4 and a channel-1 terminal count can both fall in one cycle. One path clears the interrupt flag and the other sets it. The bench first steps channel 1 to count 1. It then drives `tick` and the acknowledge read on the same clock edge and expects the flag still set, with 0 as read data. A second, lone acknowledge read must then clear the flag. A control write and a tick can also meet in one cycle, and the assertions require the control write to win by disabling the channel.

// File: rtl/tmr3_pkg.sv
package tmr3_pkg;
  localparam int NCH    = 3;
  localparam int CLK_CH = 1;
  localparam int A_CTL  = 3;
  localparam int A_ACK  = 4;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_ALT  = 2'd3
  } acc_e;

  function automatic acc_e f_access(input logic [1:0] fld);
    return acc_e'(fld);
  endfunction
endpackage

// File: rtl/tmr3_decode.sv
module tmr3_decode
  import tmr3_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        ctl_sel,
  output logic [NCH-1:0]    ctl_wr,
  output logic [NCH-1:0]    div_wr,
  output logic [NCH-1:0]    div_rd,
  output logic              ctl_rd,
  output logic              ack_rd,
  output logic              bad_ctl
);
  logic wr_ctl_addr;
  assign wr_ctl_addr = bus_sel && bus_we && (bus_addr == ADDR_W'(A_CTL));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign div_wr[i] = bus_sel && bus_we && (bus_addr == ADDR_W'(i));
    assign div_rd[i] = bus_sel && !bus_we && (bus_addr == ADDR_W'(i));
    assign ctl_wr[i] = wr_ctl_addr && (ctl_sel == 2'(i));
  end

  assign bad_ctl = wr_ctl_addr && (ctl_sel == 2'd3);
  assign ctl_rd  = bus_sel && !bus_we && (bus_addr == ADDR_W'(A_CTL));
  assign ack_rd  = bus_sel && !bus_we && (bus_addr == ADDR_W'(A_ACK));
endmodule

// File: rtl/tmr3_channel.sv
module tmr3_channel
  import tmr3_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter bit FIXED_GATE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              gate,
  input  logic              force_reload,
  input  logic              ctl_wr,
  input  logic              div_wr,
  input  logic              div_rd,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [BYTE_W-1:0] mode,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              tc_now,
  output logic              tc_pulse,
  output logic              enabled
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] mode_q;
  logic [CNT_W-1:0]  div_q, cnt_q, div_new;
  logic              en_q, tog_q, tc_q;
  logic              gate_eff, run, at_end, wr_hi, wr_take, arm;
  acc_e              acc;

  // byte merge: replace one half of the divider
  function automatic logic [CNT_W-1:0] f_merge(input logic [CNT_W-1:0] d,
                                               input logic [BYTE_W-1:0] b,
                                               input logic hi);
    return hi ? {b, d[BYTE_W-1:0]} : {d[CNT_W-1:BYTE_W], b};
  endfunction

  // one count step: from 1 reload, else decrement (0 wraps: period 2^CNT_W)
  function automatic logic [CNT_W-1:0] f_step(input logic [CNT_W-1:0] c,
                                              input logic [CNT_W-1:0] d);
    return (c == CNT_W'(1)) ? d : c - CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] f_preload(input logic [CNT_W-1:0] d);
    return d - CNT_W'(1);
  endfunction

  assign acc      = f_access(mode_q[5:4]);
  assign gate_eff = FIXED_GATE ? 1'b1 : gate;
  assign run      = en_q && gate_eff;
  assign at_end   = (cnt_q == CNT_W'(1));
  assign wr_hi    = (acc == ACC_HI) || ((acc == ACC_ALT) && tog_q);
  assign wr_take  = div_wr && (acc != ACC_NONE);
  assign arm      = (acc != ACC_ALT) || tog_q;
  assign div_new  = f_merge(div_q, wbyte, wr_hi);
  assign tc_now   = run && tick && !force_reload && at_end && !ctl_wr && !div_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      div_q  <= '0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      tog_q  <= 1'b0;
      tc_q   <= 1'b0;
    end else begin
      tc_q <= tc_now;
      if (ctl_wr) begin
        mode_q <= wbyte;
        en_q   <= 1'b0;
        tog_q  <= 1'b0;
      end else if (div_wr) begin
        if (wr_take) begin
          div_q <= div_new;
          cnt_q <= div_new;
          if (arm) en_q <= 1'b1;
          if (acc == ACC_ALT) tog_q <= ~tog_q;
        end
      end else begin
        if (div_rd && (acc == ACC_ALT)) tog_q <= ~tog_q;
        if (run && force_reload) cnt_q <= f_preload(div_q);
        else if (run && tick)    cnt_q <= f_step(cnt_q, div_q);
      end
    end
  end

  always_comb begin
    unique case (acc)
      ACC_LO:  rd_byte = cnt_q[BYTE_W-1:0];
      ACC_HI:  rd_byte = cnt_q[CNT_W-1:BYTE_W];
      ACC_ALT: rd_byte = tog_q ? cnt_q[CNT_W-1:BYTE_W] : cnt_q[BYTE_W-1:0];
      default: rd_byte = '0;
    endcase
  end

  assign mode     = mode_q;
  assign tc_pulse = tc_q;
  assign enabled  = en_q;

  // R2: a control write leaves the channel stopped
  p_ctl_disables_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !en_q);
  // R4: the channel only starts on a divider write
  p_enable_from_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(div_wr));
  // R9: the terminal pulse comes with the divider back in the count
  p_reload_at_terminal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |-> (cnt_q == div_q));
  // R10: a stopped channel keeps its count
  p_hold_when_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ctl_wr && !div_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import tmr3_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              inhibit,
  input  logic              force_reload,
  input  logic [2:0]        gate,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              clk_irq,
  output logic [2:0]        tc_out
);
  logic [NCH-1:0]             ctl_wr, div_wr, div_rd, tc_now, tc_q, ch_en;
  logic                       ctl_rd, ack_rd, bad_ctl, irq_set, irq_q;
  logic [NCH-1:0][BYTE_W-1:0] mode_a, rd_a;
  logic [1:0]                 last_sel_q;
  logic [BYTE_W-1:0]          rd_next, rdata_q;

  tmr3_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel (bus_sel),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .ctl_sel (bus_wdata[7:6]),
    .ctl_wr  (ctl_wr),
    .div_wr  (div_wr),
    .div_rd  (div_rd),
    .ctl_rd  (ctl_rd),
    .ack_rd  (ack_rd),
    .bad_ctl (bad_ctl)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    tmr3_channel #(.BYTE_W(BYTE_W), .FIXED_GATE(i == CLK_CH)) u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .gate        (gate[i]),
      .force_reload(force_reload),
      .ctl_wr      (ctl_wr[i]),
      .div_wr      (div_wr[i]),
      .div_rd      (div_rd[i]),
      .wbyte       (bus_wdata),
      .mode        (mode_a[i]),
      .rd_byte     (rd_a[i]),
      .tc_now      (tc_now[i]),
      .tc_pulse    (tc_q[i]),
      .enabled     (ch_en[i])
    );
  end

  // last valid control target, for control-register reads
  always_ff @(posedge clk) begin
    if (!rst_n) last_sel_q <= '0;
    else if (|ctl_wr) last_sel_q <= bus_wdata[7:6];
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NCH; i++) begin
      if (div_rd[i]) rd_next = rd_a[i];
      if (ctl_rd && (last_sel_q == 2'(i))) rd_next = mode_a[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else if (bus_sel && !bus_we) rdata_q <= rd_next;
  end

  // clock interrupt: set beats acknowledge
  assign irq_set = tc_now[CLK_CH] && !inhibit;
  always_ff @(posedge clk) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (irq_set) irq_q <= 1'b1;
    else if (ack_rd)  irq_q <= 1'b0;
  end

  assign bus_rdata = rdata_q;
  assign clk_irq   = irq_q;
  assign tc_out    = tc_q;

  // R1: an invalid channel select leaves modes and target untouched
  p_bad_select_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bad_ctl |=> ($stable(mode_a) && $stable(last_sel_q) && $stable(ch_en)));
  // R7: acknowledge without a competing set clears the flag
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !irq_set) |=> !clk_irq);
  // R7: a write to the acknowledge address does nothing to the flag
  p_ack_write_harmless_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_W'(A_ACK) && !irq_set) |=> $stable(clk_irq));
  // R8: the flag rises only while inhibit was low
  p_irq_needs_clear_inhibit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_irq) |-> !$past(inhibit));
  // R8: the flag rises only when the clock channel was running
  p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_irq) |-> $past(ch_en[CLK_CH]));
endmodule

// File: tb/tb_tri_interval_timer.sv
module tb_tri_interval_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, inhibit = 1'b0, force_reload = 1'b0;
  logic [2:0] gate = 3'b000;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       clk_irq;
  logic [2:0] tc_out;

  int checks = 0, errors = 0;
  int tc2_cnt = 0;
  int snap;
  logic rd_pend = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  tri_interval_timer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .inhibit(inhibit),
    .force_reload(force_reload), .gate(gate), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .clk_irq(clk_irq), .tc_out(tc_out)
  );

  always #10 clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: read data is valid one cycle after the strobe
  always @(posedge clk) begin
    rd_pend <= bus_sel && !bus_we;
    if (tc_out[2]) tc2_cnt <= tc2_cnt + 1;
  end
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6 unexpected read data actual=%0h expected=none", bus_rdata);
      end else begin
        check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    bus_read(3'd3, 8'h00, "R2 control reads 0 after reset");
    check(clk_irq, 0, "R2 irq clear after reset");
    bus_read(3'd0, 8'h00, "R5 mode 00 divider read is 0");
    bus_read(3'd6, 8'h00, "R6 unused address reads 0");

    // channel 1, alternating access (01 11 0000)
    bus_write(3'd3, 8'h70);
    bus_write(3'd1, 8'h05);
    bus_write(3'd1, 8'h00);
    bus_write(3'd3, 8'hF0);
    bus_read(3'd3, 8'h70, "R1 select 3 ignored, control keeps 0x70");
    bus_read(3'd1, 8'h05, "R5 alternating read low");
    bus_read(3'd1, 8'h00, "R5 alternating read high");
    do_ticks(3);
    bus_read(3'd1, 8'h02, "R9 count after 3 ticks low");
    bus_read(3'd1, 8'h00, "R9 count after 3 ticks high");
    do_ticks(2);
    check(clk_irq, 1, "R8 irq set at channel-1 terminal count, gate bit ignored");
    bus_read(3'd4, 8'h00, "R7 latch-clear read returns 0");
    check(clk_irq, 0, "R7 latch-clear read clears irq");

    inhibit = 1'b1;
    do_ticks(5);
    check(clk_irq, 0, "R8 inhibit blocks irq");

    // channel 0: low-only then high-only
    bus_write(3'd3, 8'h10);
    bus_write(3'd0, 8'h03);
    bus_read(3'd0, 8'h03, "R3 low-only write and read");
    bus_write(3'd3, 8'h20);
    bus_write(3'd0, 8'h01);
    bus_read(3'd0, 8'h01, "R3 high-only read");
    bus_read(3'd0, 8'h01, "R5 high-only read does not toggle");
    bus_read(3'd3, 8'h20, "R2 control read gives last mode");

    // channel 2: not enabled after only the low byte
    gate[2] = 1'b1;
    bus_write(3'd3, 8'hB0);
    bus_write(3'd2, 8'h01);
    repeat (2) @(negedge clk);
    snap = tc2_cnt;
    do_ticks(3);
    repeat (2) @(negedge clk);
    check(tc2_cnt, snap, "R4 no counting after low byte only");

    bus_write(3'd3, 8'hB0);
    bus_write(3'd2, 8'h04);
    bus_write(3'd2, 8'h00);
    gate[2] = 1'b0;
    do_ticks(2);
    gate[2] = 1'b1;
    do_ticks(1);
    bus_read(3'd2, 8'h03, "R10 gate low held count, then one step");
    bus_read(3'd2, 8'h00, "R4 high byte after full load");
    do_ticks(1);
    @(negedge clk); force_reload = 1'b1;
    @(negedge clk); force_reload = 1'b0;
    bus_read(3'd2, 8'h03, "R11 force_reload gives divider-1 on channel 2");
    bus_read(3'd2, 8'h00, "R11 high byte");
    bus_read(3'd1, 8'h04, "R11 force_reload on channel 1");
    bus_read(3'd1, 8'h00, "R11 channel 1 high byte");
    bus_read(3'd0, 8'h01, "R10 ungated channel 0 untouched");

    // acknowledge write has no effect
    inhibit = 1'b0;
    do_ticks(4);
    check(clk_irq, 1, "R8 irq after forced period");
    bus_write(3'd4, 8'hFF);
    check(clk_irq, 1, "R7 write to latch-clear ignored");
    bus_read(3'd4, 8'h00, "R7 ack read data");
    check(clk_irq, 0, "R7 ack clears irq");

    // same-cycle terminal count and acknowledge: set wins
    do_ticks(4);
    @(negedge clk);
    tick = 1'b1; bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 3'd4;
    exp_q.push_back(8'h00); tag_q.push_back("R7 ack read data in collision");
    @(negedge clk);
    tick = 1'b0; bus_sel = 1'b0;
    check(clk_irq, 1, "R7 set beats same-cycle ack");
    bus_read(3'd4, 8'h00, "R7 later ack read data");
    check(clk_irq, 0, "R7 later ack clears irq");

    // divider 0 means 65536 ticks
    inhibit = 1'b1;
    bus_write(3'd3, 8'h90);
    bus_write(3'd2, 8'h00);
    repeat (2) @(negedge clk);
    snap = tc2_cnt;
    do_ticks(65535);
    repeat (2) @(negedge clk);
    check(tc2_cnt, snap, "R9 no terminal count before 65536 ticks");
    bus_read(3'd2, 8'h01, "R9 count reaches 1 after 65535 ticks");
    do_ticks(1);
    repeat (2) @(negedge clk);
    check(tc2_cnt, snap + 1, "R9 terminal pulse at tick 65536");
    bus_read(3'd2, 8'h00, "R9 reload of divider 0");

    repeat (3) @(negedge clk);
    check(exp_q.size(), 0, "R6 all reads returned");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule